// File: doc/BRIEF.md
# Serial Identity CRC-8 Engine

This block computes the 8-bit cyclic redundancy check that guards a 64-bit device identity. The identity is laid out as a family byte, then a 48-bit serial number, then a check byte. An 8-bit accumulator absorbs one data bit per update. It can be driven bit by bit from outside, or it can be fed from a built-in sequencer that walks a whole identity word, least significant bit first, one bit per clock.

Two uses are supported. In generate mode the sequencer feeds the low 56 bits of the word, and the final remainder is the check byte to store. In verify mode it feeds all 64 bits. A well-formed identity, with its check byte in the top byte, then leaves a remainder of zero. A zero flag follows the remainder at all times, so an external bit-serial user can run the same zero-residue test.

Top module: `idcrc_engine`

## Requirements
- R1: After reset the remainder is 0x00, the zero flag is 1, and busy and done are 0.
- R2: When bit_en is high and clr, busy and an accepted start are all absent, one clock edge updates the remainder as follows. The feedback is bit_in XOR remainder bit 0. The register shifts right by one with 0 entering bit 7, and it is then XORed with 0x8C if the feedback is 1. This is the polynomial x^8+x^5+x^4+1 in reflected form.
- R3: With clr, bit_en and start all low and busy low, the remainder holds its value.
- R4: clr is synchronous and overrides every other input. After the edge the remainder is 0x00, busy is 0, and any running sequence is abandoned without a done pulse.
- R5: The zero flag is 1 exactly when the remainder is 0x00, in the same cycle and without a register delay.
- R6: start with verify=0 while not busy clears the remainder and raises busy on the same edge. The engine then feeds word_in bits 0 through 55 in that order on the next 56 edges. The remainder after the last of those edges is the check byte of those 56 bits.
- R7: start with verify=1 feeds word_in bits 0 through 63 on 64 edges. When bits 63:56 hold the check byte of bits 55:0, the final remainder is 0x00 and the zero flag is 1.
- R8: While busy, bit_en, bit_in and start have no effect on the sequence or on the remainder it produces.
- R9: done is a single-cycle pulse. It rises on the same edge on which the last bit enters and busy falls, so the remainder is final while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of remainder and sequencer |
| bit_en | input | 1 | Absorb bit_in on this edge (ignored while busy) |
| bit_in | input | 1 | Serial data bit |
| start | input | 1 | Begin a word sequence (ignored while busy) |
| verify | input | 1 | Sequence length select at start: 0 = 56 bits, 1 = 64 bits |
| word_in | input | 64 | Identity word, sampled on the accepted start edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse marking the end of a sequence |
| remainder | output | 8 | Current accumulator value |
| zero | output | 1 | Remainder equals zero |

## Verification
The assertions assume that inputs only change away from the rising edge and that word_in and verify matter only on an accepted start edge. They make no assumption about bit_en or start while busy, because those inputs must be ignored then. The stimulus drives every input just after the falling edge. It mixes random serial traffic and random clears with whole-word sequences, and it toggles bit_en and start during sequences on purpose so that the ignore rule is exercised rather than assumed.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
    localparam int unsigned CRC_W_DEF   = 8;
    localparam int unsigned ID_W_DEF    = 64;
    localparam logic [7:0]  POLY_R_DEF  = 8'h8C;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } feed_phase_e;
endpackage

// File: rtl/idcrc_step.sv
module idcrc_step #(
    parameter int unsigned      W    = idcrc_pkg::CRC_W_DEF,
    parameter logic [W-1:0]     POLY = W'(idcrc_pkg::POLY_R_DEF)
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    output logic [W-1:0] rem_o
);
    logic fb;

    always_comb begin
        fb    = bit_i ^ rem_i[0];
        rem_o = rem_i >> 1;
        if (fb) begin
            rem_o = rem_o ^ POLY;
        end
    end
endmodule

// File: rtl/idcrc_accum.sv
module idcrc_accum #(
    parameter int unsigned      W    = idcrc_pkg::CRC_W_DEF,
    parameter logic [W-1:0]     POLY = W'(idcrc_pkg::POLY_R_DEF)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic         bit_i,
    output logic [W-1:0] rem_o
);
    typedef struct packed {
        logic [W-1:0] rem;
    } acc_t;

    acc_t         acc_d, acc_q;
    logic [W-1:0] stepped;

    idcrc_step #(.W(W), .POLY(POLY)) u_step (
        .rem_i (acc_q.rem),
        .bit_i (bit_i),
        .rem_o (stepped)
    );

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d.rem = '0;
        end else if (step_i) begin
            acc_d.rem = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign rem_o = acc_q.rem;
endmodule

// File: rtl/idcrc_feeder.sv
module idcrc_feeder
    import idcrc_pkg::*;
#(
    parameter int unsigned ID_W  = ID_W_DEF,
    parameter int unsigned CRC_W = CRC_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            start_i,
    input  logic            verify_i,
    input  logic [ID_W-1:0] word_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            step_o,
    output logic            bit_o
);
    localparam int unsigned DATA_W = ID_W - CRC_W;
    localparam int unsigned CNT_W  = $clog2(ID_W + 1);

    typedef struct packed {
        feed_phase_e     phase;
        logic [ID_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic            done;
    } feed_t;

    feed_t feed_d, feed_q;

    always_comb begin
        feed_d      = feed_q;
        feed_d.done = 1'b0;
        if (clr_i) begin
            feed_d.phase = PH_IDLE;
            feed_d.cnt   = '0;
        end else if (feed_q.phase == PH_IDLE) begin
            if (start_i) begin
                feed_d.phase = PH_RUN;
                feed_d.sh    = word_i;
                feed_d.cnt   = verify_i ? CNT_W'(ID_W) : CNT_W'(DATA_W);
            end
        end else begin
            feed_d.sh  = feed_q.sh >> 1;
            feed_d.cnt = feed_q.cnt - 1'b1;
            if (feed_q.cnt == CNT_W'(1)) begin
                feed_d.phase = PH_IDLE;
                feed_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feed_q <= '{phase: PH_IDLE, sh: '0, cnt: '0, done: 1'b0};
        end else begin
            feed_q <= feed_d;
        end
    end

    assign busy_o = (feed_q.phase == PH_RUN);
    assign step_o = (feed_q.phase == PH_RUN);
    assign bit_o  = feed_q.sh[0];
    assign done_o = feed_q.done;
endmodule

// File: rtl/idcrc_engine.sv
module idcrc_engine
    import idcrc_pkg::*;
#(
    parameter int unsigned      CRC_W = CRC_W_DEF,
    parameter int unsigned      ID_W  = ID_W_DEF,
    parameter logic [CRC_W-1:0] POLY  = CRC_W'(POLY_R_DEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             start,
    input  logic             verify,
    input  logic [ID_W-1:0]  word_in,
    output logic             busy,
    output logic             done,
    output logic [CRC_W-1:0] remainder,
    output logic             zero
);
    logic feed_busy;
    logic feed_step;
    logic feed_bit;
    logic start_ok;
    logic acc_clr;
    logic acc_step;
    logic acc_bit;

    idcrc_feeder #(.ID_W(ID_W), .CRC_W(CRC_W)) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .start_i  (start),
        .verify_i (verify),
        .word_i   (word_in),
        .busy_o   (feed_busy),
        .done_o   (done),
        .step_o   (feed_step),
        .bit_o    (feed_bit)
    );

    always_comb begin
        start_ok = start & ~feed_busy;
        acc_clr  = clr | start_ok;
        acc_step = feed_busy ? feed_step : bit_en;
        acc_bit  = feed_busy ? feed_bit  : bit_in;
    end

    idcrc_accum #(.W(CRC_W), .POLY(POLY)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (acc_clr),
        .step_i (acc_step),
        .bit_i  (acc_bit),
        .rem_o  (remainder)
    );

    assign busy = feed_busy;
    assign zero = (remainder == '0);
endmodule

// File: rtl/idcrc_engine_checker.sv
module idcrc_engine_checker #(
    parameter int unsigned CRC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             bit_en,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CRC_W-1:0] remainder,
    input logic             zero
);
    p_clr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (remainder == '0) && !busy && !done)
        else $error("clr did not clear the engine");

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !bit_en && !start && !busy) |=> $stable(remainder))
        else $error("remainder moved while idle");

    p_start_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !clr) |=> busy && zero)
        else $error("start not accepted");

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("done while busy");

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(clr)) |-> done)
        else $error("sequence ended without done");

    p_no_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> !done)
        else $error("done without a sequence");
endmodule

bind idcrc_engine idcrc_engine_checker #(.CRC_W(CRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .bit_en    (bit_en),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .remainder (remainder),
    .zero      (zero)
);

// File: tb/idcrc_engine_bench.sv
module idcrc_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        start = 1'b0;
    logic        verify = 1'b0;
    logic [63:0] word_in = '0;
    logic        busy, done, zero;
    logic [7:0]  remainder;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idcrc_engine u_idcrc_engine (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
        .start(start), .verify(verify), .word_in(word_in),
        .busy(busy), .done(done), .remainder(remainder), .zero(zero)
    );

    function automatic logic [7:0] ref_step(input logic [7:0] r, input logic b);
        logic f;
        f = b ^ r[0];
        r = r >> 1;
        if (f) r = r ^ 8'h8C;
        return r;
    endfunction

    function automatic logic [7:0] ref_crc(input logic [63:0] w, input int n);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < n; i++) r = ref_step(r, w[i]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        clr = 1'b0; bit_en = 1'b0; bit_in = 1'b0; start = 1'b0;
    endtask

    // Runs one word sequence; noise toggles bit_en/bit_in and a stray start mid-run (R8)
    task automatic run_seq(input logic [63:0] w, input bit ver, input bit noise);
        int n;
        logic [7:0] exp;
        bit busy_ok;
        n = ver ? 64 : 56;
        exp = ref_crc(w, n);
        start = 1'b1; verify = ver; word_in = w;
        tick();
        start = 1'b0;
        chk(busy == 1'b1 && remainder == 8'h00, "R6 start clears and raises busy", {busy, remainder}, {1'b1, 8'h00});
        busy_ok = 1'b1;
        for (int i = 1; i <= n; i++) begin
            if (noise) begin
                bit_en = 1'($urandom);
                bit_in = 1'($urandom);
                start  = (i == 9) || (i == n - 2);
                word_in = {$urandom, $urandom};
                verify = 1'($urandom);
            end
            tick();
            if (i < n && (busy !== 1'b1 || done !== 1'b0)) busy_ok = 1'b0;
        end
        idle_inputs();
        chk(busy_ok, "R9 busy held for whole sequence", 64'(busy_ok), 64'd1);
        chk(done == 1'b1 && busy == 1'b0, "R9 done with busy low on last bit", {done, busy}, 2'b10);
        chk(remainder == exp, ver ? (noise ? "R8 verify result under noise" : "R7 verify remainder")
                                  : (noise ? "R8 generate result under noise" : "R6 generated check byte"),
            remainder, exp);
        tick();
        chk(done == 1'b0, "R9 done is one cycle", done, 0);
        chk(remainder == exp, "R3 result held after done", remainder, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  m;
        logic [55:0] d;
        logic [7:0]  c;
        logic [63:0] id;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk(remainder == 8'h00 && zero == 1'b1 && busy == 1'b0 && done == 1'b0,
            "R1 reset state", {remainder, zero, busy, done}, {8'h00, 3'b100});
        rst_n = 1'b1;
        tick();
        chk(remainder == 8'h00 && zero, "R1 idle after reset", remainder, 0);

        // single bit 1 from zero: feedback 1 -> 0x8C
        bit_en = 1'b1; bit_in = 1'b1;
        tick();
        chk(remainder == 8'h8C, "R2 one bit into zero register", remainder, 8'h8C);
        chk(zero == 1'b0, "R5 zero flag low on nonzero", zero, 0);
        bit_en = 1'b0;
        repeat (3) tick();
        chk(remainder == 8'h8C, "R3 hold with bit_en low", remainder, 8'h8C);
        clr = 1'b1; bit_en = 1'b1; bit_in = 1'b1;
        tick();
        idle_inputs();
        chk(remainder == 8'h00 && zero, "R4 clr beats bit_en", remainder, 0);

        // random serial traffic against model
        m = 8'h00;
        for (int k = 0; k < 400; k++) begin
            clr    = ($urandom % 23) == 0;
            bit_en = 1'($urandom);
            bit_in = 1'($urandom);
            tick();
            if (clr) m = 8'h00;
            else if (bit_en) m = ref_step(m, bit_in);
            chk(remainder == m, clr ? "R4 random clear" : (bit_en ? "R2 random serial step" : "R3 random hold"), remainder, m);
            chk(zero == (m == 8'h00), "R5 zero flag tracks remainder", zero, 64'(m == 8'h00));
        end
        idle_inputs();

        // serial full identity: generate then zero residue
        d = {$urandom, $urandom};
        c = ref_crc({8'h00, d}, 56);
        id = {c, d};
        chk(ref_crc(id, 64) == 8'h00, "R7 bench model residue", ref_crc(id, 64), 0);
        clr = 1'b1; tick(); clr = 1'b0;
        for (int i = 0; i < 56; i++) begin bit_en = 1'b1; bit_in = id[i]; tick(); end
        chk(remainder == c, "R6 serial check byte", remainder, c);
        for (int i = 56; i < 64; i++) begin bit_en = 1'b1; bit_in = id[i]; tick(); end
        idle_inputs();
        chk(remainder == 8'h00 && zero, "R7 serial zero residue", remainder, 0);

        // sequencer: directed corners
        run_seq(64'h0, 1'b0, 1'b0);
        run_seq(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        run_seq(64'h0000_0000_0000_0001, 1'b1, 1'b0);
        bit_en = 1'b1; bit_in = 1'b1; tick(); idle_inputs();  // dirty register before start
        run_seq({ref_crc({8'h00, 56'h00A5_5A00_FF01_02}, 56), 56'h00A5_5A00_FF01_02}, 1'b1, 1'b0);
        chk(zero == 1'b1, "R7 verify good identity flags zero", zero, 1);

        // random sequences, good, corrupted, with noise
        for (int k = 0; k < 24; k++) begin
            d = {$urandom, $urandom};
            c = ref_crc({8'h00, d}, 56);
            case (k % 4)
                0: run_seq({8'h00, d}, 1'b0, 1'b0);
                1: run_seq({c, d}, 1'b1, 1'b0);
                2: run_seq({c ^ 8'h01, d}, 1'b1, 1'b0);
                default: run_seq({c, d}, 1'(k % 8 == 3), 1'b1);
            endcase
        end

        // clr during a sequence
        start = 1'b1; verify = 1'b1; word_in = {$urandom, $urandom};
        tick(); start = 1'b0;
        repeat (20) tick();
        clr = 1'b1; bit_en = 1'b1;
        tick(); idle_inputs();
        chk(remainder == 8'h00 && busy == 1'b0 && done == 1'b0, "R4 clr aborts sequence",
            {remainder, busy, done}, 0);
        repeat (50) begin
            tick();
            if (done) chk(1'b0, "R4 no done after abort", done, 0);
        end
        chk(remainder == 8'h00, "R4 register stays clear after abort", remainder, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule